// File: doc/BRIEF.md
# Self-Aligning Test-Pattern Checker with Error Counters

This block sits behind a link receiver and checks each parallel word against a selected test pattern. It supports four pseudo-random sequences and two square-wave patterns. For the pseudo-random sequences it loads its local generator from a received word. For the square patterns it finds the bit rotation of the received word. No external alignment step is needed. After a run of clean words it declares lock. From then on it accumulates the number of bits tested and the number of bits found wrong. Software divides the two counts to form the bit error rate.

Control uses single-cycle pulses. `start` samples the pattern selection and begins searching. `stop` returns the checker to idle and leaves the counters untouched. `clr` zeroes both counters. Each counter is a saturating register. A long soak test therefore never wraps to a small number.

States: IDLE (not checking), SEARCH (waiting for a word to seed from or align to), VERIFY (counting clean words toward lock), LOCKED (counting bits and errors). Transitions:
- start: any state to SEARCH.
- stop: any state to IDLE.
- seed_ok: SEARCH to VERIFY.
- verify_fail: VERIFY to VERIFY or SEARCH. The checker reseeds from the failing word.
- lock_ok: VERIFY to LOCKED.
- lose_lock: LOCKED to SEARCH.

Top module: `bert_rx_checker`

## Requirements
- R1: After `rst`, `bits_tested` and `err_bits` are zero and `locked` and `running` are low.
- R2: A `start` pulse without `stop` sets `running` and clears `locked` on the next cycle. A `stop` pulse (which wins over `start`) clears `running` and `locked` on the next cycle. While stopped, valid words leave both counters unchanged.
- R3: Pattern codes 0..3 select sequences of degree 7, 15, 23 and 31. Each obeys s[t] = s[t-n] xor s[t-k], with (n,k) = (7,6), (15,14), (23,18) and (31,28). Bit 0 of a word is the earliest in time. The first valid word after `start` seeds the checker. After 8 further consecutive error-free words, `locked` is high.
- R4: Code 4 selects a low-rate square pattern: the word 0x0000FFFF, rotated left by any amount. Code 5 (and codes 6 and 7) select a high-rate pattern: 0xAAAAAAAA, rotated. A word matching any rotation seeds the checker. Lock then follows after 8 more matching words, as in R3.
- R5: On each valid word while locked, `bits_tested` grows by the word width (32). `err_bits` grows by the popcount of the received word xor the expected word.
- R6: No counting takes place while `locked` is low or `rx_valid` is low.
- R7: While locked, 4 consecutive valid words that each hold more than 8 bit errors drop the lock. Fewer such words in a row, or words with at most 8 errors, keep it.
- R8: Both counters saturate at all-ones instead of wrapping.
- R9: A `clr` pulse zeroes both counters on the next cycle.
- R10: `pat_sel` is sampled only on `start`. Changing it later has no effect on the running check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: sample pattern, begin search |
| stop | input | 1 | Pulse: return to idle, counters kept |
| clr | input | 1 | Pulse: zero both counters |
| rx_valid | input | 1 | Received word is valid this cycle |
| rx_data | input | W | Received word, bit 0 earliest |
| pat_sel | input | 3 | Pattern code (see R3, R4) |
| bits_tested | output | CNT_W | Saturating count of bits checked while locked |
| err_bits | output | CNT_W | Saturating count of wrong bits while locked |
| locked | output | 1 | Checker is aligned and counting |
| running | output | 1 | Checker is not idle |

## Verification
The assertions assume the following about the inputs:
- `rst` is high from time zero.
- A `start` and a `stop` in the same cycle resolve in favour of `stop`.
- The word width is at least 32 bits, so that one word holds a full generator state.

The stimulus stays within these assumptions. It drives all inputs one nanosecond after the rising edge. It raises each control pulse for exactly one cycle and never overlaps `start` with `stop`. It sends only uninterrupted pattern streams, with errors placed by flipping chosen low-order bits. The saturation assertions and checks use a second instance with 8-bit counters, so the limit is reached within a short run.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam logic [2:0] PAT_PRBS7  = 3'd0;
    localparam logic [2:0] PAT_PRBS15 = 3'd1;
    localparam logic [2:0] PAT_PRBS23 = 3'd2;
    localparam logic [2:0] PAT_PRBS31 = 3'd3;
    localparam logic [2:0] PAT_LOWF   = 3'd4;
    localparam logic [2:0] PAT_HIGHF  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_VERIFY = 2'd2,
        ST_LOCKED = 2'd3
    } chk_state_e;

    // Feedback taps: s[t] = s[t-long] ^ s[t-short]
    function automatic int tap_long(logic [2:0] sel);
        case (sel)
            PAT_PRBS7:  return 7;
            PAT_PRBS15: return 15;
            PAT_PRBS23: return 23;
            default:    return 31;
        endcase
    endfunction

    function automatic int tap_short(logic [2:0] sel);
        case (sel)
            PAT_PRBS7:  return 6;
            PAT_PRBS15: return 14;
            PAT_PRBS23: return 18;
            default:    return 28;
        endcase
    endfunction

endpackage

// File: rtl/bert_prbs_predict.sv
// Predicts the next word of the stream from the previous expected word.
// For square patterns every word repeats, so the prediction is the input.
module bert_prbs_predict
    import bert_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] prev_word,
    input  logic [2:0]   sel,
    output logic [W-1:0] next_word
);
    logic [2*W-1:0] ext;

    always_comb begin
        int tl;
        int ts;
        tl  = tap_long(sel);
        ts  = tap_short(sel);
        ext = {{W{1'b0}}, prev_word};
        for (int i = 0; i < W; i++) begin
            ext[W+i] = ext[W+i-tl] ^ ext[W+i-ts];
        end
        next_word = (sel <= PAT_PRBS31) ? ext[2*W-1:W] : prev_word;
    end
endmodule

// File: rtl/bert_square_align.sv
// Flags whether the word equals any rotation of the selected square reference.
module bert_square_align
    import bert_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] word,
    input  logic [2:0]   sel,
    output logic         hit
);
    localparam logic [W-1:0] LOW_REF  = {{(W/2){1'b0}}, {(W/2){1'b1}}};
    localparam logic [W-1:0] HIGH_REF = {(W/2){2'b10}};

    logic [W-1:0] refw;
    logic [W-1:0] match;

    assign refw = (sel == PAT_LOWF) ? LOW_REF : HIGH_REF;

    for (genvar r = 0; r < W; r++) begin : g_rot
        if (r == 0) begin : g_zero
            assign match[r] = (word == refw);
        end else begin : g_shift
            assign match[r] = (word == {refw[W-1-r:0], refw[W-1:W-r]});
        end
    end

    assign hit = |match;
endmodule

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    localparam int SW = CNT_W + 1;

    logic [SW-1:0] sum;
    assign sum = {1'b0, count} + SW'(inc);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en) begin
            count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/bert_rx_checker.sv
module bert_rx_checker
    import bert_pkg::*;
#(
    parameter int W         = 32,
    parameter int CNT_W     = 48,
    parameter int LOCK_GOOD = 8,
    parameter int LOSS_BAD  = 4,
    parameter int BAD_BITS  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             clr,
    input  logic             rx_valid,
    input  logic [W-1:0]     rx_data,
    input  logic [2:0]       pat_sel,
    output logic [CNT_W-1:0] bits_tested,
    output logic [CNT_W-1:0] err_bits,
    output logic             locked,
    output logic             running
);
    localparam int PW = $clog2(W + 1);
    localparam int GW = $clog2(LOCK_GOOD + 1);
    localparam int BW = $clog2(LOSS_BAD + 1);

    chk_state_e     state, state_n;
    logic [2:0]     sel_q;
    logic [W-1:0]   ref_q;
    logic [GW-1:0]  good_q;
    logic [BW-1:0]  bad_q;

    logic [W-1:0]   pred;
    logic [PW-1:0]  nerr;
    logic           word_ok, heavy, sq_hit, seed_ok, go, cnt_en;

    bert_prbs_predict #(.W(W)) u_pred (
        .prev_word (ref_q),
        .sel       (sel_q),
        .next_word (pred)
    );

    bert_square_align #(.W(W)) u_align (
        .word (rx_data),
        .sel  (sel_q),
        .hit  (sq_hit)
    );

    assign nerr    = PW'($countones(rx_data ^ pred));
    assign word_ok = (nerr == '0);
    assign heavy   = (nerr > PW'(BAD_BITS));
    assign seed_ok = (sel_q <= PAT_PRBS31) || sq_hit;
    assign go      = start && !stop;

    // Next state
    always_comb begin
        state_n = state;
        if (stop) begin
            state_n = ST_IDLE;
        end else if (start) begin
            state_n = ST_SEARCH;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_SEARCH:
                    if (rx_valid && seed_ok) state_n = ST_VERIFY;
                ST_VERIFY:
                    if (rx_valid) begin
                        if (!word_ok)
                            state_n = seed_ok ? ST_VERIFY : ST_SEARCH;
                        else if (good_q == GW'(LOCK_GOOD - 1))
                            state_n = ST_LOCKED;
                    end
                ST_LOCKED:
                    if (rx_valid && heavy && bad_q == BW'(LOSS_BAD - 1))
                        state_n = ST_SEARCH;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // Alignment datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= PAT_PRBS7;
            ref_q  <= '0;
            good_q <= '0;
            bad_q  <= '0;
        end else if (go) begin
            sel_q  <= pat_sel;
            good_q <= '0;
            bad_q  <= '0;
        end else if (rx_valid && !stop) begin
            unique case (state)
                ST_IDLE: ;
                ST_SEARCH: begin
                    if (seed_ok) ref_q <= rx_data;
                    good_q <= '0;
                end
                ST_VERIFY: begin
                    if (word_ok) begin
                        ref_q  <= pred;
                        good_q <= good_q + 1'b1;
                    end else begin
                        ref_q  <= rx_data;
                        good_q <= '0;
                    end
                end
                ST_LOCKED: begin
                    ref_q <= pred;
                    if (!heavy || bad_q == BW'(LOSS_BAD - 1)) bad_q <= '0;
                    else                                       bad_q <= bad_q + 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        locked  = (state == ST_LOCKED);
        running = (state != ST_IDLE);
        cnt_en  = locked && rx_valid;
    end

    bert_sat_counter #(.CNT_W(CNT_W), .INC_W(PW)) u_bits (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .en    (cnt_en),
        .inc   (PW'(W)),
        .count (bits_tested)
    );

    bert_sat_counter #(.CNT_W(CNT_W), .INC_W(PW)) u_errs (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .en    (cnt_en),
        .inc   (nerr),
        .count (err_bits)
    );
endmodule

// File: rtl/bert_rx_checker_sva.sv
module bert_rx_checker_sva #(
    parameter int W     = 32,
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             stop,
    input logic             clr,
    input logic             rx_valid,
    input logic [CNT_W-1:0] bits_tested,
    input logic [CNT_W-1:0] err_bits,
    input logic             locked,
    input logic             running
);
    localparam logic [CNT_W-1:0] STEP_MAX = {CNT_W{1'b1}} - CNT_W'(W);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!running && !locked));

    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> (running && !locked));

    p_lock_in_run_r2: assert property (@(posedge clk) disable iff (rst)
        locked |-> running);

    p_hold_unlocked_r6: assert property (@(posedge clk) disable iff (rst)
        (!locked && !clr) |=> ($stable(bits_tested) && $stable(err_bits)));

    p_hold_novalid_r6: assert property (@(posedge clk) disable iff (rst)
        (!rx_valid && !clr) |=> ($stable(bits_tested) && $stable(err_bits)));

    p_bits_step_r5: assert property (@(posedge clk) disable iff (rst)
        (locked && rx_valid && !clr && bits_tested <= STEP_MAX)
        |=> (bits_tested == $past(bits_tested) + CNT_W'(W)));

    p_err_bound_r5: assert property (@(posedge clk) disable iff (rst)
        err_bits <= bits_tested);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (bits_tested >= $past(bits_tested) && err_bits >= $past(err_bits)));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bits_tested == '0 && err_bits == '0));
endmodule

bind bert_rx_checker bert_rx_checker_sva #(.W(W), .CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .stop        (stop),
    .clr         (clr),
    .rx_valid    (rx_valid),
    .bits_tested (bits_tested),
    .err_bits    (err_bits),
    .locked      (locked),
    .running     (running)
);

// File: tb/bert_rx_checker_test.sv
`timescale 1ns/1ps
module bert_rx_checker_test;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, stop = 1'b0, clr = 1'b0, rx_valid = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic [2:0]   pat_sel = '0;
    logic [47:0]  bits_tested, err_bits;
    logic         locked, running;
    logic [7:0]   s_bits, s_errs;
    logic         s_locked, s_running;

    int checks = 0;
    int errors = 0;
    logic [63:0]  hist = 64'h5A5A_C3C3_0F0F_9669;
    logic [W-1:0] sq_word = '0;
    logic [2:0]   cur_pat = '0;
    logic [47:0]  snap_b, snap_e;

    // pattern, rotation, flipped bits in third counted word
    localparam logic [11:0] VEC [8] = '{
        {3'd0, 5'd0,  4'd1},
        {3'd1, 5'd0,  4'd2},
        {3'd2, 5'd0,  4'd3},
        {3'd3, 5'd0,  4'd0},
        {3'd4, 5'd5,  4'd2},
        {3'd4, 5'd20, 4'd0},
        {3'd5, 5'd1,  4'd1},
        {3'd5, 5'd0,  4'd3}
    };

    always #2.5 clk = ~clk;

    bert_rx_checker uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .clr(clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .pat_sel(pat_sel),
        .bits_tested(bits_tested), .err_bits(err_bits),
        .locked(locked), .running(running)
    );

    bert_rx_checker #(.CNT_W(8)) uut_sat (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .clr(clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .pat_sel(pat_sel),
        .bits_tested(s_bits), .err_bits(s_errs),
        .locked(s_locked), .running(s_running)
    );

    function automatic int t_long(logic [2:0] p);
        case (p) 3'd0: return 7; 3'd1: return 15; 3'd2: return 23; default: return 31; endcase
    endfunction
    function automatic int t_short(logic [2:0] p);
        case (p) 3'd0: return 6; 3'd1: return 14; 3'd2: return 18; default: return 28; endcase
    endfunction
    function automatic logic [W-1:0] rotl(logic [W-1:0] x, int r);
        return (r == 0) ? x : ((x << r) | (x >> (W - r)));
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_word(output logic [W-1:0] w);
        if (cur_pat <= 3'd3) begin
            for (int i = 0; i < W; i++) begin
                logic b;
                b = hist[t_long(cur_pat)-1] ^ hist[t_short(cur_pat)-1];
                hist = {hist[62:0], b};
                w[i] = b;
            end
        end else begin
            w = sq_word;
        end
    endtask

    task automatic send_pat(int flips);
        logic [W-1:0] w;
        next_word(w);
        for (int i = 0; i < flips; i++) w[i] = ~w[i];
        rx_valid = 1'b1;
        rx_data  = w;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic pulse_start(logic [2:0] p);
        pat_sel = p; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask
    task automatic pulse_stop();
        stop = 1'b1; @(posedge clk); #1; stop = 1'b0;
    endtask
    task automatic pulse_clr();
        clr = 1'b1; @(posedge clk); #1; clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 bits", bits_tested, 0);
        check("R1 errs", err_bits, 0);
        check("R1 locked", locked, 0);
        check("R1 running", running, 0);

        // Table of pattern scenarios
        for (int v = 0; v < 8; v++) begin
            logic [2:0] p;
            logic [4:0] r;
            logic [3:0] f;
            {p, r, f} = VEC[v];
            cur_pat = p;
            sq_word = (p == 3'd4) ? rotl(32'h0000FFFF, int'(r)) : rotl(32'hAAAAAAAA, int'(r));
            pulse_clr();
            pulse_start(p);
            check("R2 running after start", running, 1);
            repeat (9) send_pat(0);
            check((p <= 3'd3) ? "R3 lock" : "R4 lock", locked, 1);
            check("R6 nothing counted before lock", bits_tested, 0);
            for (int j = 0; j < 5; j++) send_pat((j == 2) ? int'(f) : 0);
            check("R5 bits", bits_tested, 5 * W);
            check("R5 errs", err_bits, f);
        end

        // R6 valid low while locked
        snap_b = bits_tested; snap_e = err_bits;
        repeat (5) @(posedge clk);
        #0;
        check("R6 bits hold", bits_tested, snap_b);
        check("R6 errs hold", err_bits, snap_e);

        // R7 loss of lock
        cur_pat = 3'd3;
        pulse_clr();
        pulse_start(3'd3);
        repeat (9) send_pat(0);
        check("R3 prbs31 lock", locked, 1);
        repeat (3) send_pat(9);
        send_pat(0);
        check("R7 three heavy words keep lock", locked, 1);
        repeat (4) send_pat(9);
        check("R7 four heavy words drop lock", locked, 0);
        check("R7 bits", bits_tested, 8 * W);
        check("R7 errs", err_bits, 63);
        repeat (9) send_pat(0);
        check("R3 relock", locked, 1);
        check("R6 no count while relocking", bits_tested, 8 * W);

        // R10 pattern select sampled at start
        cur_pat = 3'd0;
        pulse_start(3'd0);
        pat_sel = 3'd5;
        repeat (9) send_pat(0);
        check("R10 select change ignored", locked, 1);

        // R2 stop
        snap_b = bits_tested; snap_e = err_bits;
        pulse_stop();
        check("R2 stop running", running, 0);
        check("R2 stop locked", locked, 0);
        repeat (3) send_pat(0);
        check("R2 bits held after stop", bits_tested, snap_b);
        check("R2 errs held after stop", err_bits, snap_e);

        // R9 clear
        pulse_clr();
        check("R9 bits cleared", bits_tested, 0);
        check("R9 errs cleared", err_bits, 0);

        // R8 saturation on the narrow instance
        cur_pat = 3'd1;
        pulse_start(3'd1);
        repeat (9) send_pat(0);
        repeat (8) send_pat(0);
        check("R8 bits saturate", s_bits, 255);
        repeat (32) send_pat(8);
        check("R8 errs saturate", s_errs, 255);
        check("R8 bits stay saturated", s_bits, 255);
        check("R5 wide errs", err_bits, 256);
        check("R7 eight-error words keep lock", s_locked, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule